// File: doc/BRIEF.md
# Selectable Multistage Interpolation Filter

This block raises the sample rate of a complex baseband stream of 12-bit I and Q samples by 1, 2, 4 or 8. It chains up to three halfband FIR stages in polyphase form. Each stage doubles the rate. The stages are linear phase with symmetric taps (-1, 0, 9, 16, 9, 0, -1)/16. The rate setting decides how many stages are in the path; the 1x setting skips all of them.

The clock runs at the output rate. The upstream source raises `in_valid` once every N cycles, where N is the selected factor. The block marks each output sample with a one-cycle `out_ce` strobe. A highpass option flips the sign of every second output, which moves the passband to the upper image.

Any change on the mode pins empties every delay line. `out_valid` then stays low until the pipeline has been refilled.

Top module: `interp_chain`

## Requirements
- R1: `factor_sel` selects the factor N: 0 gives 1x, 1 gives 2x, 2 gives 4x and 3 gives 8x. In 1x mode a sample accepted at clock edge t appears unchanged on `out_i`/`out_q`, with `out_ce` high, after edge t+2.
- R2: With inputs paced one per N cycles, every input produces exactly N output strobes. Once the stream is running, the strobes come on consecutive clock cycles.
- R3: Each stage turns input x[n] into two outputs, in this order: round((9·(x[n-1]+x[n-2]) − x[n] − x[n-3])/16), then x[n-1]. History before the first input after a mode change is zero. For N>1 the stages cascade, and each stage's output stream is the input stream of the next.
- R4: Rounding adds 8 to the 16-times-scaled sum and then shifts it arithmetically right by 4 (round half up).
- R5: Every stage result is saturated to the range −2048..2047.
- R6: With `hp_sel`=1, outputs with odd index are negated, counting from 0 after the last mode change. The negation saturates, so −2048 becomes 2047.
- R7: When `factor_sel` or `hp_sel` differs from the value in use, the block clears all delay lines and pending outputs. On the next cycle `out_ce` and `out_valid` are both low.
- R8: `out_valid` marks output k (counted from 0 after reset or the last mode change) as valid if and only if k ≥ 4·N. Once high, it stays high until the next mode change.
- R9: I and Q go through identical and independent paths. A Q input that is all zero gives a Q output that is all zero.
- R10: During and right after reset, `out_ce`, `out_valid`, `out_i` and `out_q` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| factor_sel | input | 2 | Interpolation factor code (0:1x, 1:2x, 2:4x, 3:8x) |
| hp_sel | input | 1 | 1 selects the highpass (mirrored) response |
| in_valid | input | 1 | Input sample strobe, one per N cycles |
| in_i | input | 12 | Input I sample, two's complement |
| in_q | input | 12 | Input Q sample, two's complement |
| out_ce | output | 1 | Output sample strobe |
| out_valid | output | 1 | High once the pipeline has refilled |
| out_i | output | 12 | Output I sample |
| out_q | output | 12 | Output Q sample |

## Verification
A wrong delay-line state, such as history left over after a mode change, shows up in the very first output strobe after a new input. That output would no longer equal −x/16, and the value carried forward one strobe later would not be zero. A stage whose second-output counter runs wrong breaks the steady strobe pattern within one input period: it produces gaps or extra strobes, and the output count differs from N per input. An error in the sign phase or in the refill counter shows up on the first odd sample or exactly at sample 4·N. Every rate is driven with values near full scale, so saturation and rounding faults reach the ports within a few strobes.

// File: rtl/interp_pkg.sv
// Shared constants for the interpolation chain.
// Assumes: a 7-tap halfband prototype (-1,0,9,16,9,0,-1)/16. The centre
// tap equals the scale, so the centre phase is a pure delay.
package interp_pkg;
    localparam int HB_TAP_INNER = 9;   // taps next to the centre
    localparam int HB_TAP_OUTER = -1;  // outermost nonzero taps
    localparam int HB_SHIFT     = 4;   // divide by 16 after the sum
    localparam int HB_HIST      = 3;   // stored past samples per channel
endpackage

// File: rtl/hb_mac.sv
// Combinational odd-phase arithmetic of one halfband stage, one channel.
// Sums the two symmetric tap pairs, rounds half up and saturates to DW bits.
// Assumes: the accumulator has 6 spare bits, so the sum cannot overflow.
module hb_mac
    import interp_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic signed [DW-1:0] x_new,
    input  logic signed [DW-1:0] x_d1,
    input  logic signed [DW-1:0] x_d2,
    input  logic signed [DW-1:0] x_d3,
    output logic signed [DW-1:0] y_mid
);
    localparam int AW = DW + 6;
    localparam logic signed [AW-1:0] K_IN  = AW'(HB_TAP_INNER);
    localparam logic signed [AW-1:0] K_OUT = AW'(HB_TAP_OUTER);
    localparam logic signed [AW-1:0] RND   = AW'(1 << (HB_SHIFT - 1));
    localparam logic signed [AW-1:0] Y_MAX = AW'((1 << (DW - 1)) - 1);
    localparam logic signed [AW-1:0] Y_MIN = AW'(-(1 << (DW - 1)));

    logic signed [AW-1:0] pair_in;
    logic signed [AW-1:0] pair_out;
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] scaled;

    // Symmetric pre-add, two multiplies, round half up, clamp.
    always_comb begin
        pair_in  = AW'(x_d1) + AW'(x_d2);
        pair_out = AW'(x_new) + AW'(x_d3);
        acc      = K_IN * pair_in + K_OUT * pair_out;
        scaled   = (acc + RND) >>> HB_SHIFT;
        if (scaled > Y_MAX) begin
            y_mid = Y_MAX[DW-1:0];
        end else if (scaled < Y_MIN) begin
            y_mid = Y_MIN[DW-1:0];
        end else begin
            y_mid = scaled[DW-1:0];
        end
    end
endmodule

// File: rtl/hb_stage.sv
// One x2 halfband stage in polyphase form, for both I and Q.
// On each accepted input it emits the odd-phase value on the next cycle.
// It emits the centre-phase value (a delayed sample) `half` cycles later.
// Assumes: inputs arrive no faster than once per 2*half cycles, and
// clr empties the history and any pending output.
module hb_stage
    import interp_pkg::*;
#(
    parameter int DW = 12,
    parameter int CW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic [CW-1:0]        half,
    input  logic                 in_ce,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    output logic                 out_ce,
    output logic signed [DW-1:0] out_i,
    output logic signed [DW-1:0] out_q
);
    localparam int NCH = 2;

    logic          take;
    logic          emit_ctr;
    logic          pend;
    logic [CW-1:0] cnt;

    assign take     = en && in_ce;
    assign emit_ctr = !take && pend && (cnt == half);

    // Sequencing: the odd phase follows an input, the centre phase follows after `half` cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            out_ce <= 1'b0;
            pend   <= 1'b0;
            cnt    <= '0;
        end else begin
            out_ce <= take || emit_ctr;
            if (take) begin
                pend <= 1'b1;
                cnt  <= CW'(1);
            end else if (emit_ctr) begin
                pend <= 1'b0;
            end else if (pend) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic signed [DW-1:0] din;
        logic signed [DW-1:0] hist [HB_HIST];
        logic signed [DW-1:0] mid;
        logic signed [DW-1:0] yo;

        if (ch == 0) begin : g_i
            assign din   = in_i;
            assign out_i = yo;
        end else begin : g_q
            assign din   = in_q;
            assign out_q = yo;
        end

        hb_mac #(.DW(DW)) u_mac (
            .x_new (din),
            .x_d1  (hist[0]),
            .x_d2  (hist[1]),
            .x_d3  (hist[2]),
            .y_mid (mid)
        );

        // History shift and output register for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                for (int t = 0; t < HB_HIST; t++) hist[t] <= '0;
                yo <= '0;
            end else if (take) begin
                hist[0] <= din;
                for (int t = 1; t < HB_HIST; t++) hist[t] <= hist[t-1];
                yo <= mid;
            end else if (emit_ctr) begin
                yo <= hist[1];
            end
        end
    end

    AST_STAGE_PACING: assert property (@(posedge clk) disable iff (!rst_n || clr)
        take |-> !pend);  // R2
    AST_STAGE_FIRST: assert property (@(posedge clk) disable iff (!rst_n || clr)
        take |=> out_ce);  // R3
endmodule

// File: rtl/out_mirror.sv
// Output stage: optional sign alternation (highpass mirror) and refill tracking.
// Counts output strobes since the last clear. It raises out_valid once the
// count reaches fill_target.
// Assumes: clr arrives on every mode change, which restarts the sign phase.
module out_mirror #(
    parameter int DW = 12,
    parameter int FW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 hp,
    input  logic [FW-1:0]        fill_target,
    input  logic                 in_ce,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    output logic                 out_ce,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_i,
    output logic signed [DW-1:0] out_q
);
    logic          odd;
    logic [FW-1:0] seen;

    function automatic logic signed [DW-1:0] neg_sat(input logic signed [DW-1:0] v);
        if (v == {1'b1, {(DW-1){1'b0}}}) return {1'b0, {(DW-1){1'b1}}};
        return -v;
    endfunction

    // Register each strobe, flip the sign on odd samples in highpass mode, count towards refill.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            out_ce    <= 1'b0;
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
            odd       <= 1'b0;
            seen      <= '0;
        end else begin
            out_ce <= in_ce;
            if (in_ce) begin
                out_i     <= (hp && odd) ? neg_sat(in_i) : in_i;
                out_q     <= (hp && odd) ? neg_sat(in_q) : in_q;
                odd       <= !odd;
                out_valid <= (seen >= fill_target);
                if (seen < fill_target) seen <= seen + 1'b1;
            end
        end
    end

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n || clr)
        out_valid |=> out_valid);  // R8
endmodule

// File: rtl/interp_chain.sv
// Top of the selectable interpolation chain (x1/x2/x4/x8) for complex samples.
// factor_sel gives the number of active halfband stages. Each stage's
// second-output spacing is derived from that number. A change on the mode
// pins flushes the whole pipeline.
// Assumes: the clock runs at the output rate and in_valid is paced once
// per 2**factor_sel cycles.
module interp_chain
    import interp_pkg::*;
#(
    parameter int DW         = 12,
    parameter int NSTG       = 3,
    parameter int FILL_DEPTH = 4,
    localparam int FACW      = $clog2(NSTG + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FACW-1:0]      factor_sel,
    input  logic                 hp_sel,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    output logic                 out_ce,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_i,
    output logic signed [DW-1:0] out_q
);
    localparam int CW = NSTG;
    localparam int FW = $clog2(FILL_DEPTH) + NSTG + 1;

    logic [FACW-1:0] rate_q;
    logic            hp_q;
    logic            flush;

    logic                 sce [NSTG+1];
    logic signed [DW-1:0] sdi [NSTG+1];
    logic signed [DW-1:0] sdq [NSTG+1];

    logic                 fin_ce;
    logic signed [DW-1:0] fin_i;
    logic signed [DW-1:0] fin_q;
    logic [FW-1:0]        fill_target;

    assign flush = (factor_sel != rate_q) || (hp_sel != hp_q);

    // Hold the mode in use; any difference on the pins is taken as a change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '0;
            hp_q   <= 1'b0;
        end else if (flush) begin
            rate_q <= factor_sel;
            hp_q   <= hp_sel;
        end
    end

    // Input register feeding the head of the chain.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            sce[0] <= 1'b0;
            sdi[0] <= '0;
            sdq[0] <= '0;
        end else begin
            sce[0] <= in_valid;
            if (in_valid) begin
                sdi[0] <= in_i;
                sdq[0] <= in_q;
            end
        end
    end

    for (genvar k = 0; k < NSTG; k++) begin : g_stg
        logic          en_k;
        logic [CW-1:0] half_k;

        assign en_k   = int'(rate_q) > k;
        assign half_k = CW'((1 << rate_q) >> (k + 1));

        hb_stage #(.DW(DW), .CW(CW)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (flush),
            .en     (en_k),
            .half   (half_k),
            .in_ce  (sce[k]),
            .in_i   (sdi[k]),
            .in_q   (sdq[k]),
            .out_ce (sce[k+1]),
            .out_i  (sdi[k+1]),
            .out_q  (sdq[k+1])
        );
    end

    // Pick the tap of the chain that matches the active factor.
    always_comb begin
        fin_ce = sce[0];
        fin_i  = sdi[0];
        fin_q  = sdq[0];
        for (int k = 1; k <= NSTG; k++) begin
            if (int'(rate_q) == k) begin
                fin_ce = sce[k];
                fin_i  = sdi[k];
                fin_q  = sdq[k];
            end
        end
    end

    assign fill_target = FW'(FILL_DEPTH << rate_q);

    out_mirror #(.DW(DW), .FW(FW)) u_mirror (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (flush),
        .hp          (hp_q),
        .fill_target (fill_target),
        .in_ce       (fin_ce),
        .in_i        (fin_i),
        .in_q        (fin_q),
        .out_ce      (out_ce),
        .out_valid   (out_valid),
        .out_i       (out_i),
        .out_q       (out_q)
    );

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!out_ce && !out_valid));  // R7
    AST_BYPASS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ce && rate_q == '0) |-> $past(in_valid, 2));  // R1
endmodule

// File: tb/interp_chain_tb.sv
module interp_chain_tb;
    localparam int NV = 8;
    localparam int NS = 6;
    localparam int V_RATE [NV] = '{0, 1, 1, 2, 3, 3, 0, 2};
    localparam int V_HP   [NV] = '{0, 0, 1, 0, 0, 1, 1, 1};
    localparam int V_SAMP [NV][NS] = '{
        '{100, -200, 2047, -2048, 5, 0},
        '{160, 320, -480, 1000, -1000, 7},
        '{2047, 2047, -2048, -2048, 2047, 2047},
        '{16, -16, 33, -33, 1024, -1024},
        '{500, 500, 500, 500, 500, 500},
        '{-2048, 2047, -2048, 2047, 300, -300},
        '{-2048, -2048, 1, 1, 2047, 2047},
        '{700, -50, 0, 0, -900, 1234}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        factor_sel = 2'd0;
    logic              hp_sel = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [11:0] in_i = '0;
    logic signed [11:0] in_q = '0;
    logic              out_ce;
    logic              out_valid;
    logic signed [11:0] out_i;
    logic signed [11:0] out_q;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;
    bit capturing = 1'b0;
    int cyc = 0;
    int cap_n = 0;
    int cap_i [64];
    int cap_q [64];
    int cap_v [64];
    int cap_t [64];

    interp_chain u_dut (
        .clk(clk), .rst_n(rst_n), .factor_sel(factor_sel), .hp_sel(hp_sel),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_ce(out_ce), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (capturing && out_ce && cap_n < 64) begin
            cap_i[cap_n] = int'(out_i);
            cap_q[cap_n] = int'(out_q);
            cap_v[cap_n] = int'(out_valid);
            cap_t[cap_n] = cyc;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic string vtag(input int v);
        case (v)
            0: return "R1";
            1: return "R3";
            2: return "R5";
            3: return "R4";
            4: return "R2";
            default: return "R6";
        endcase
    endfunction

    function automatic int sat12(input int v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    // One x2 step of the requirement-level halfband response (R3, R4, R5).
    task automatic hb_up(inout int a[64], input int len);
        int t[64];
        for (int n = 0; n < len; n++) begin
            int x1, x2, x3, v;
            x1 = 0; x2 = 0; x3 = 0;
            if (n >= 1) x1 = a[n-1];
            if (n >= 2) x2 = a[n-2];
            if (n >= 3) x3 = a[n-3];
            v = 9 * (x1 + x2) - x3 - a[n];
            v = (v + 8) >>> 4;
            t[2*n]     = sat12(v);
            t[2*n + 1] = x1;
        end
        a = t;
    endtask

    task automatic set_mode(input int rate, input bit hp);
        @(negedge clk);
        factor_sel = 2'(rate);
        hp_sel = !hp;
        repeat (3) @(negedge clk);
        hp_sel = hp;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_vec(input int v);
        int rate, nper, len;
        int ri[64];
        int rq[64];
        string tag;
        rate = V_RATE[v];
        nper = 1 << rate;
        tag = vtag(v);
        set_mode(rate, V_HP[v] != 0);
        cap_n = 0;
        capturing = 1'b1;
        for (int k = 0; k < NS; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_i = 12'(V_SAMP[v][k]);
            in_q = 12'(V_SAMP[v][NS-1-k]);
            for (int w = 1; w < nper; w++) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (20) @(negedge clk);
        capturing = 1'b0;
        for (int k = 0; k < 64; k++) begin
            ri[k] = 0;
            rq[k] = 0;
        end
        for (int k = 0; k < NS; k++) begin
            ri[k] = V_SAMP[v][k];
            rq[k] = V_SAMP[v][NS-1-k];
        end
        len = NS;
        for (int s = 0; s < rate; s++) begin
            hb_up(ri, len);
            hb_up(rq, len);
            len = len * 2;
        end
        if (V_HP[v] != 0) begin
            for (int k = 1; k < len; k += 2) begin
                ri[k] = sat12(-ri[k]);
                rq[k] = sat12(-rq[k]);
            end
        end
        chk("R2", $sformatf("vec%0d output count", v), cap_n, len);
        for (int k = 0; k < len && k < cap_n; k++) begin
            chk(tag, $sformatf("vec%0d I[%0d]", v, k), cap_i[k], ri[k]);
            chk("R9", $sformatf("vec%0d Q[%0d]", v, k), cap_q[k], rq[k]);
            chk("R8", $sformatf("vec%0d valid[%0d]", v, k), cap_v[k], (k >= (4 << rate)) ? 1 : 0);
            if (k > 0) chk("R2", $sformatf("vec%0d strobe gap[%0d]", v, k), cap_t[k] - cap_t[k-1], 1);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state while reset is held
        chk("R10", "out_ce in reset", int'(out_ce), 0);
        chk("R10", "out_valid in reset", int'(out_valid), 0);
        chk("R10", "out_i in reset", int'(out_i), 0);
        chk("R10", "out_q in reset", int'(out_q), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10", "out_ce after reset", int'(out_ce), 0);
        chk("R10", "out_valid after reset", int'(out_valid), 0);

        for (int v = 0; v < NV; v++) run_vec(v);

        // R1: bypass latency, two edges from acceptance to output
        set_mode(0, 1'b0);
        @(negedge clk);
        in_valid = 1'b1;
        in_i = 12'sd777;
        in_q = -12'sd5;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1", "out_ce one edge after accept", int'(out_ce), 0);
        @(negedge clk);
        chk("R1", "out_ce two edges after accept", int'(out_ce), 1);
        chk("R1", "bypass I value", int'(out_i), 777);
        chk("R1", "bypass Q value", int'(out_q), -5);

        // R7: mode change mid-stream clears history and silences the output
        set_mode(1, 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_i = 12'sd1000;
            in_q = 12'sd1000;
            @(negedge clk);
            in_valid = 1'b0;
        end
        hp_sel = 1'b1;
        @(negedge clk);
        chk("R7", "out_ce after mode change", int'(out_ce), 0);
        chk("R7", "out_valid after mode change", int'(out_valid), 0);
        hp_sel = 1'b0;
        repeat (3) @(negedge clk);
        cap_n = 0;
        capturing = 1'b1;
        in_valid = 1'b1;
        in_i = 12'sd1600;
        in_q = 12'sd0;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (10) @(negedge clk);
        capturing = 1'b0;
        chk("R7", "outputs after flush", cap_n, 2);
        chk("R7", "odd phase with cleared history", cap_i[0], -100);
        chk("R7", "centre phase with cleared history", cap_i[1], 0);
        chk("R9", "zero Q stays zero (first)", cap_q[0], 0);
        chk("R9", "zero Q stays zero (second)", cap_q[1], 0);
        chk("R8", "not valid during refill", cap_v[1], 0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end
endmodule